// File: doc/BRIEF.md
# Two-Level Paged Address Translator

This block maps 32-bit linear addresses onto physical addresses using 4 KB pages. A requester presents an address and a write flag on a valid/ready channel. The block answers on a second valid/ready channel with either a physical address or a page fault. When translation is switched off, the address passes straight through. When it is switched on, the block first consults a small fully associative cache of recent translations. If that misses, it reads a first-level directory entry and then a second-level table entry through a single 32-bit memory read port. It then caches the result and answers.

Software points the block at the first-level directory through a base input and pulses a flush input whenever that base is rewritten. Faults return the offending linear address on a dedicated output. That output holds its value until the next fault.

Top module: `pgx_xlate`

## Requirements
- R1: When translation is disabled at acceptance, the response arrives in the cycle after acceptance with physical address equal to the linear address, no fault and no memory read.
- R2: The first walk read is at {dir_base[31:12], la[31:22], 2'b00}. The second read is at {dir_entry[31:12], la[21:12], 2'b00}. A good result is {table_entry[31:12], la[11:0]}.
- R3: A cached translation answers in the cycle after acceptance with zero memory reads.
- R4: A miss with both entries present performs exactly two memory reads and caches the translation, so a repeat of the same page hits.
- R5: An entry whose bit 0 (present) is clear faults. A clear directory entry stops the walk after one read. A clear table entry stops it after two. The fault address output captures the linear address, and nothing is cached, so a repeat walks again.
- R6: A write to a page whose table entry has bit 1 (writable) clear faults, both on a cache hit and at the end of a walk. Reads of the same page succeed.
- R7: The flush input invalidates every cached translation. A fill that falls in a cycle with flush high is discarded.
- R8: The cache holds 32 translations, replaced round-robin. The replacement pointer restarts at entry 0 on reset and on flush.
- R9: After reset the response is invalid, no memory read is pending, the fault address is zero and a request can be accepted. A request is only accepted while no translation is in flight. A response holds until taken. A memory read holds its address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pg_en_i | input | 1 | Translation enable, sampled at acceptance |
| dir_base_i | input | 32 | Directory base; bits 31:12 used |
| flush_i | input | 1 | Invalidate all cached translations |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Request is a write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_fault_o | output | 1 | Response is a page fault |
| fault_addr_o | output | 32 | Linear address of the latest fault |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
The fill of a freshly walked translation and a flush can land on the same clock edge. The bench provokes this by holding the flush input high for the whole walk of a new page. The response must still carry the correct physical address. A second request to that page must then cost two memory reads again, which shows that flush took priority over the fill. Replacement order is judged the same way, by counting reads after 33 distinct pages.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned VPN_W  = ADDR_W - OFF_W;
  localparam int unsigned ENT_B  = 2;   // log2 of entry size in bytes
  localparam int unsigned BIT_P  = 0;   // present
  localparam int unsigned BIT_W  = 1;   // writable

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_RSP  = 2'd3
  } st_e;
endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  output logic             hit_wr_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_wr_i
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] wr_q;
  logic [VPN_W-1:0] vpn_q [DEPTH];
  logic [PFN_W-1:0] pfn_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (vpn_q[i] == lk_vpn_i);
  end

  // at most one entry matches: fills only follow misses
  always_comb begin
    hit_pfn_o = '0;
    hit_wr_o  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_pfn_o = hit_pfn_o | ({PFN_W{match[i]}} & pfn_q[i]);
      hit_wr_o  = hit_wr_o  | (match[i] & wr_q[i]);
    end
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= (ptr_q == PTR_MAX) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) begin
      vpn_q[ptr_q] <= fill_vpn_i;
      pfn_q[ptr_q] <= fill_pfn_i;
      wr_q[ptr_q]  <= fill_wr_i;
    end
  end
endmodule

// File: rtl/pgx_walk.sv
module pgx_walk
  import pgx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_en_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              hit_i,
  input  logic [VPN_W-1:0]  hit_pfn_i,
  input  logic              hit_wr_i,
  output logic              fill_o,
  output logic [VPN_W-1:0]  fill_vpn_o,
  output logic [VPN_W-1:0]  fill_pfn_o,
  output logic              fill_wr_o
);
  st_e               st_q;
  logic [ADDR_W-1:0] la_q;
  logic              wr_q;
  logic [VPN_W-1:0]  tbase_q;
  logic [ADDR_W-1:0] paddr_q;
  logic              fault_q;
  logic [ADDR_W-1:0] faddr_q;

  logic accept;
  logic ent_p, ent_w, tbl_ok;
  logic unused_bits;

  assign unused_bits = ^{mem_rdata_i[OFF_W-1:BIT_W+1], dir_base_i[OFF_W-1:0]};

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign ent_p       = mem_rdata_i[BIT_P];
  assign ent_w       = mem_rdata_i[BIT_W];
  assign tbl_ok      = ent_p && !(wr_q && !ent_w);

  always_comb begin
    if (st_q == ST_DIR)
      mem_addr_o = {dir_base_i[ADDR_W-1:OFF_W], la_q[ADDR_W-1:ADDR_W-IDX_W], {ENT_B{1'b0}}};
    else
      mem_addr_o = {tbase_q, la_q[OFF_W+IDX_W-1:OFF_W], {ENT_B{1'b0}}};
  end
  assign mem_req_o = (st_q == ST_DIR) || (st_q == ST_TBL);

  assign fill_o     = (st_q == ST_TBL) && mem_ack_i && tbl_ok;
  assign fill_vpn_o = la_q[ADDR_W-1:OFF_W];
  assign fill_pfn_o = mem_rdata_i[ADDR_W-1:OFF_W];
  assign fill_wr_o  = ent_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      la_q    <= '0;
      wr_q    <= 1'b0;
      tbase_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      faddr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          la_q <= req_addr_i;
          wr_q <= req_write_i;
          if (!pg_en_i) begin
            paddr_q <= req_addr_i;
            fault_q <= 1'b0;
            st_q    <= ST_RSP;
          end else if (hit_i) begin
            if (req_write_i && !hit_wr_i) begin
              paddr_q <= '0;
              fault_q <= 1'b1;
              faddr_q <= req_addr_i;
            end else begin
              paddr_q <= {hit_pfn_i, req_addr_i[OFF_W-1:0]};
              fault_q <= 1'b0;
            end
            st_q <= ST_RSP;
          end else begin
            st_q <= ST_DIR;
          end
        end
        ST_DIR: if (mem_ack_i) begin
          if (!ent_p) begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            faddr_q <= la_q;
            st_q    <= ST_RSP;
          end else begin
            tbase_q <= mem_rdata_i[ADDR_W-1:OFF_W];
            st_q    <= ST_TBL;
          end
        end
        ST_TBL: if (mem_ack_i) begin
          if (tbl_ok) begin
            paddr_q <= {mem_rdata_i[ADDR_W-1:OFF_W], la_q[OFF_W-1:0]};
            fault_q <= 1'b0;
          end else begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            faddr_q <= la_q;
          end
          st_q <= ST_RSP;
        end
        ST_RSP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o  = (st_q == ST_RSP);
  assign rsp_paddr_o  = paddr_q;
  assign rsp_fault_o  = fault_q;
  assign fault_addr_o = faddr_q;
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int unsigned TLB_DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_en_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  logic             tlb_hit, hit_eff, hit_wr;
  logic [VPN_W-1:0] hit_pfn;
  logic             fill;
  logic [VPN_W-1:0] fill_vpn, fill_pfn;
  logic             fill_wr;

  // a lookup in a flush cycle sees an empty cache
  assign hit_eff = tlb_hit && !flush_i;

  pgx_tlb #(.DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .PFN_W(VPN_W)) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .lk_vpn_i   (req_addr_i[ADDR_W-1:OFF_W]),
    .hit_o      (tlb_hit),
    .hit_pfn_o  (hit_pfn),
    .hit_wr_o   (hit_wr),
    .fill_i     (fill),
    .fill_vpn_i (fill_vpn),
    .fill_pfn_i (fill_pfn),
    .fill_wr_i  (fill_wr)
  );

  pgx_walk u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pg_en_i      (pg_en_i),
    .dir_base_i   (dir_base_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .req_write_i  (req_write_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_fault_o  (rsp_fault_o),
    .fault_addr_o (fault_addr_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .hit_i        (hit_eff),
    .hit_pfn_i    (hit_pfn),
    .hit_wr_i     (hit_wr),
    .fill_o       (fill),
    .fill_vpn_o   (fill_vpn),
    .fill_pfn_o   (fill_pfn),
    .fill_wr_o    (fill_wr)
  );
endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pg_en_i,
  input logic [31:0] dir_base_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [31:0] rsp_paddr_o,
  input logic        rsp_fault_o,
  input logic [31:0] fault_addr_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i
);
  logic [31:0] la_cap;
  logic        first_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      la_cap   <= '0;
      first_rd <= 1'b0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        la_cap   <= req_addr_i;
        first_rd <= 1'b1;
      end else if (mem_ack_i) begin
        first_rd <= 1'b0;
      end
    end
  end

  assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !pg_en_i) |=>
      (rsp_valid_o && !rsp_fault_o && rsp_paddr_o == $past(req_addr_i)));

  assert_dir_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && first_rd) |->
      (mem_addr_o == {dir_base_i[31:12], la_cap[31:22], 2'b00}));

  assert_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[11:0] == la_cap[11:0]));

  assert_fault_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (fault_addr_o == la_cap));

  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

  assert_mem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !req_ready_o);
endmodule

bind pgx_xlate pgx_xlate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pg_en_i      (pg_en_i),
  .dir_base_i   (dir_base_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_addr_i   (req_addr_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_fault_o  (rsp_fault_o),
  .fault_addr_o (fault_addr_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i)
);

// File: tb/pgx_xlate_tb.sv
module pgx_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_en = 1'b0;
  logic [31:0] dir_base = 32'h0010_0000;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [31:0] fault_addr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;

  always #5 clk = ~clk;

  pgx_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pg_en_i(pg_en), .dir_base_i(dir_base),
    .flush_i(flush), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .fault_addr_o(fault_addr), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // page memory model: dir at 0x0010_0000, tables at 0x0200_0000 + hi*4K
  function automatic logic [31:0] mem_model(input logic [31:0] a);
    logic [9:0] hi, lo;
    if (a[31:12] == 20'h00100) begin
      hi = a[11:2];
      if (hi == 10'h3FF) return 32'h0;
      return {8'h02, 2'b00, hi, 12'h003};
    end else if (a[31:24] == 8'h02) begin
      hi = a[21:12];
      lo = a[11:2];
      if (lo == 10'h3FF) return 32'h0;
      return {hi ^ 10'h2A5, lo ^ 10'h0F0, 10'b0, ~lo[0], 1'b1};
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] a);
    return {a[31:22] ^ 10'h2A5, a[21:12] ^ 10'h0F0, a[11:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem_model(mem_addr);
      if (mem_ack) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic xact(input logic [31:0] a, input bit w, input bit en,
                      output logic [31:0] pa, output bit f, output int nrd,
                      output int lat);
    int r0;
    @(negedge clk);
    pg_en = en; req_addr = a; req_write = w; req_valid = 1'b1;
    r0 = rd_cnt;
    lat = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 100) begin
      lat++;
      @(negedge clk);
    end
    if (lat >= 100) chk(1'b0, "R9", "response timeout", 32'(lat), 32'd0);
    pa = rsp_paddr;
    f = rsp_fault;
    nrd = rd_cnt - r0;
    @(posedge clk);
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic        en;
    logic        f;
    logic [1:0]  rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 1'b0, 1'b0, 1'b0, 2'd0}, // R1 bypass
    '{32'h0040_1ABC, 1'b0, 1'b1, 1'b0, 2'd2}, // R2 R4 walk
    '{32'h0040_1DEF, 1'b0, 1'b1, 1'b0, 2'd0}, // R3 hit
    '{32'h0040_1000, 1'b1, 1'b1, 1'b1, 2'd0}, // R6 write, hit, read-only
    '{32'hFFC0_0000, 1'b0, 1'b1, 1'b1, 2'd1}, // R5 dir absent
    '{32'h0FFF_F123, 1'b0, 1'b1, 1'b1, 2'd2}, // R5 table absent
    '{32'h0FFF_F123, 1'b0, 1'b1, 1'b1, 2'd2}, // R5 no fill
    '{32'h0080_2010, 1'b1, 1'b1, 1'b0, 2'd2}, // R6 writable walk
    '{32'h0080_2FFF, 1'b0, 1'b1, 1'b0, 2'd0}, // R3 hit
    '{32'h0080_3004, 1'b1, 1'b1, 1'b1, 2'd2}  // R6 write fault on walk
  };

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    #1_000_000ns;
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    bit f;
    int nrd, lat;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req == 1'b0, "R9", "reset mem_req", 32'(mem_req), 32'd0);
    chk(fault_addr == 32'd0, "R9", "reset fault_addr", fault_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      xact(VECS[i].a, VECS[i].w, VECS[i].en, pa, f, nrd, lat);
      chk(f == VECS[i].f, "R5_R6", $sformatf("vec %0d fault", i), 32'(f), 32'(VECS[i].f));
      chk(nrd == int'(VECS[i].rd), "R2_R4_R5", $sformatf("vec %0d reads", i), 32'(nrd), 32'(VECS[i].rd));
      if (!VECS[i].f) begin
        chk(pa == (VECS[i].en ? exp_pa(VECS[i].a) : VECS[i].a), "R1_R2",
            $sformatf("vec %0d paddr", i), pa, VECS[i].en ? exp_pa(VECS[i].a) : VECS[i].a);
      end else begin
        chk(fault_addr == VECS[i].a, "R5", $sformatf("vec %0d fault addr", i), fault_addr, VECS[i].a);
      end
      if (VECS[i].rd == 2'd0)
        chk(lat == 0, "R3_R1", $sformatf("vec %0d latency", i), 32'(lat), 32'd0);
    end

    // R6: read of read-only page succeeds from cache
    xact(32'h0040_1000, 1'b0, 1'b1, pa, f, nrd, lat);
    chk(!f && pa == exp_pa(32'h0040_1000), "R6", "read of read-only page", pa, exp_pa(32'h0040_1000));

    // R7: flush empties the cache
    pulse_flush();
    xact(32'h0080_2010, 1'b0, 1'b1, pa, f, nrd, lat);
    chk(nrd == 2, "R7", "walk after flush", 32'(nrd), 32'd2);

    // R7: fill coinciding with flush is dropped
    @(negedge clk); flush = 1'b1;
    xact(32'h00C0_5000, 1'b0, 1'b1, pa, f, nrd, lat);
    @(negedge clk); flush = 1'b0;
    chk(!f && pa == exp_pa(32'h00C0_5000), "R7", "paddr during flush", pa, exp_pa(32'h00C0_5000));
    xact(32'h00C0_5000, 1'b0, 1'b1, pa, f, nrd, lat);
    chk(nrd == 2, "R7", "fill under flush discarded", 32'(nrd), 32'd2);

    // R8: round-robin over 32 entries
    pulse_flush();
    for (int k = 0; k <= 32; k++) begin
      xact(32'h0040_0000 | (32'(k) << 12), 1'b0, 1'b1, pa, f, nrd, lat);
      if (nrd != 2) chk(1'b0, "R8", $sformatf("fill %0d reads", k), 32'(nrd), 32'd2);
    end
    xact(32'h0040_0000, 1'b0, 1'b1, pa, f, nrd, lat);
    chk(nrd == 2, "R8", "oldest evicted", 32'(nrd), 32'd2);
    xact(32'h0040_2000, 1'b0, 1'b1, pa, f, nrd, lat);
    chk(nrd == 0, "R8", "third entry kept", 32'(nrd), 32'd0);
    xact(32'h0040_1000, 1'b0, 1'b1, pa, f, nrd, lat);
    chk(nrd == 2, "R8", "second entry evicted by refill", 32'(nrd), 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule